// File: doc/BRIEF.md
# Subroutine Call, Return and Indirect Jump Sequencer

This block produces the bus activity for three control-transfer instructions of an 8-bit processor: subroutine call, subroutine return and jump through a memory pointer. It holds the 16-bit program counter and the 8-bit stack pointer. The stack is fixed to one 256-byte page, given by a parameter, with a default of page 1. While idle, the block drives a read at the program counter, which is the opcode fetch. An external decoder looks at the fetched byte, raises `op_start` and gives the instruction kind in the same cycle, which is cycle 1. From the next cycle on, the block issues one bus access per cycle until the instruction completes. It then returns to idle with the new program counter on the bus.

Every bus output is registered, and the address for each cycle is computed one cycle ahead. Read data is sampled at the clock edge that ends the cycle in which its address was driven. The call pushes the address of its own last operand byte, high byte first, and the return adds one after popping. This way a call followed by a return continues at the byte right after the three-byte call. In the indirect jump, the second pointer byte is fetched by incrementing only the low pointer byte, so a pointer that sits at the end of a page wraps to the start of that same page.

Top module: `callseq_top`

## Requirements
- R1: While reset is high and in the first cycle after it, pc equals PC_RESET, sp equals SP_RESET, bus_addr equals PC_RESET, and bus_we, busy and done are all 0.
- R2: While idle, the block drives a read (bus_we=0) at bus_addr=pc. op_kind is decoded as 2'b01 call, 2'b10 return and 2'b11 indirect jump. A start with op_kind 2'b00 leaves the block idle with pc unchanged. A start that arrives while busy is ignored.
- R3: A call started at pc=P with stack pointer S takes 6 cycles. The bus accesses in cycles 2 to 6 are: read P+1, read {page,S}, write {page,S}, write {page,S-1}, read P+2.
- R4: The call writes the high byte of P+2 in its first write cycle and the low byte of P+2 in its second write cycle. Afterwards sp equals S-2.
- R5: After a call, pc equals {byte at P+2, byte at P+1}.
- R6: A return started at pc=P with stack pointer S takes 6 cycles. The bus accesses in cycles 2 to 6 are all reads, at P+1, {page,S}, {page,S+1}, {page,S+2}, and then {hi,lo}. Here lo is the byte at {page,S+1} and hi is the byte at {page,S+2}. Afterwards pc equals {hi,lo}+1 and sp equals S+2.
- R7: A call at address P, followed by a matching return, leaves pc at P+3.
- R8: An indirect jump at P takes 5 cycles. The bus accesses in cycles 2 to 5 are reads at P+1, P+2, {ph,pl} and {ph,pl+1}, where pl is the byte at P+1 and ph is the byte at P+2. Afterwards pc equals {byte read in cycle 5, byte read in cycle 4}.
- R9: In the indirect jump, pl+1 wraps within 8 bits without carrying into ph. A pointer of 16'h02FF therefore fetches its second byte from 16'h0200.
- R10: sp wraps modulo 256 on both push and pop, and every stack access stays on the stack page.
- R11: busy is high from cycle 2 to the last cycle of an instruction. done is high for exactly the one idle cycle that follows the instruction.
- R12: bus_we is high only in the two consecutive push cycles of a call, and only at an address on the stack page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | The opcode fetched in this idle cycle is one of the handled instructions |
| op_kind | input | 2 | Instruction kind: 01 call, 10 return, 11 indirect jump |
| rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Bus address for the current cycle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write data during write cycles |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse in the first idle cycle after an instruction |

## Verification
The stimulus runs a nested pair of calls and unwinds it with two returns. This shows that the pushed value is the last operand byte and not the return address, because only then do both returns land three bytes past their calls. The stack pointer starts at 1, so the pushes cross 00 into FF and the pops cross back. A wrong wrap shows up as an address off the stack page. Two indirect jumps are run, one with a pointer at a page end and one inside a page. A carried increment changes only the first of them. Starts that carry the empty kind, or that arrive while the block is busy, confirm that the bus sequence is unchanged.

// File: rtl/callseq_pkg.sv
package callseq_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_CALL = 2'b01,
    K_RET  = 2'b10,
    K_JIND = 2'b11
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_C2, S_C3, S_C4, S_C5, S_C6,
    S_R2, S_R3, S_R4, S_R5, S_R6,
    S_I2, S_I3, S_I4, S_I5
  } step_e;

endpackage

// File: rtl/callseq_ctrl.sv
module callseq_ctrl
  import callseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  output step_e      step,
  output logic       launch,
  output logic       busy,
  output logic       done
);

  step_e step_n;
  logic  finish;

  assign launch = (step == S_IDLE) && op_start && (kind_e'(op_kind) != K_NONE);
  assign finish = (step == S_C6) || (step == S_R6) || (step == S_I5);
  assign busy   = (step != S_IDLE);

  always_comb begin
    step_n = step;
    unique case (step)
      S_IDLE: begin
        if (launch) begin
          unique case (kind_e'(op_kind))
            K_CALL:  step_n = S_C2;
            K_RET:   step_n = S_R2;
            K_JIND:  step_n = S_I2;
            default: step_n = S_IDLE;
          endcase
        end
      end
      S_C2: step_n = S_C3;
      S_C3: step_n = S_C4;
      S_C4: step_n = S_C5;
      S_C5: step_n = S_C6;
      S_C6: step_n = S_IDLE;
      S_R2: step_n = S_R3;
      S_R3: step_n = S_R4;
      S_R4: step_n = S_R5;
      S_R5: step_n = S_R6;
      S_R6: step_n = S_IDLE;
      S_I2: step_n = S_I3;
      S_I3: step_n = S_I4;
      S_I4: step_n = S_I5;
      S_I5: step_n = S_IDLE;
      default: step_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= S_IDLE;
      done <= 1'b0;
    end else begin
      step <= step_n;
      done <= finish;
    end
  end

endmodule

// File: rtl/callseq_stack.sv
module callseq_stack #(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_RESET   = 8'hFD,
  localparam int         ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [DATA_W-1:0] sp,
  output logic [ADDR_W-1:0] stk_at,
  output logic [ADDR_W-1:0] stk_dn,
  output logic [ADDR_W-1:0] stk_up
);

  logic [DATA_W-1:0] sp_dn;
  logic [DATA_W-1:0] sp_up;
  logic [DATA_W-1:0] page;

  assign page   = DATA_W'(STACK_PAGE);
  assign sp_dn  = sp - 1'b1;
  assign sp_up  = sp + 1'b1;
  assign stk_at = {page, sp};
  assign stk_dn = {page, sp_dn};
  assign stk_up = {page, sp_up};

  always_ff @(posedge clk) begin
    if (rst)       sp <= DATA_W'(SP_RESET);
    else if (push) sp <= sp_dn;
    else if (pop)  sp <= sp_up;
  end

endmodule

// File: rtl/callseq_datapath.sv
module callseq_datapath
  import callseq_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_RESET   = 8'hFD,
  parameter logic [15:0] PC_RESET  = 16'h0000,
  localparam int        ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic              launch,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] sp,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata
);

  logic [ADDR_W-1:0] pc_n, addr_n, pc_inc;
  logic [DATA_W-1:0] lat_lo, lat_hi, lat_lo_n, lat_hi_n, lat_lo_inc;
  logic [DATA_W-1:0] wd_n;
  logic              we_n, push, pop;
  logic [ADDR_W-1:0] stk_at, stk_dn, stk_up;

  callseq_stack #(
    .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .SP_RESET(SP_RESET)
  ) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .sp(sp), .stk_at(stk_at), .stk_dn(stk_dn), .stk_up(stk_up)
  );

  assign pc_inc     = pc + 1'b1;
  assign lat_lo_inc = lat_lo + 1'b1;

  always_comb begin
    pc_n     = pc;
    addr_n   = pc;
    lat_lo_n = lat_lo;
    lat_hi_n = lat_hi;
    we_n     = 1'b0;
    wd_n     = '0;
    push     = 1'b0;
    pop      = 1'b0;
    unique case (step)
      S_IDLE: begin
        if (launch) begin
          pc_n   = pc_inc;
          addr_n = pc_inc;
        end
      end
      // call
      S_C2: begin
        lat_lo_n = rdata;
        pc_n     = pc_inc;
        addr_n   = stk_at;
      end
      S_C3: begin
        addr_n = stk_at;
        we_n   = 1'b1;
        wd_n   = pc[ADDR_W-1:DATA_W];
      end
      S_C4: begin
        push   = 1'b1;
        addr_n = stk_dn;
        we_n   = 1'b1;
        wd_n   = pc[DATA_W-1:0];
      end
      S_C5: begin
        push   = 1'b1;
        addr_n = pc;
      end
      S_C6: begin
        pc_n   = {rdata, lat_lo};
        addr_n = {rdata, lat_lo};
      end
      // return
      S_R2: addr_n = stk_at;
      S_R3: begin
        pop    = 1'b1;
        addr_n = stk_up;
      end
      S_R4: begin
        pop      = 1'b1;
        lat_lo_n = rdata;
        addr_n   = stk_up;
      end
      S_R5: begin
        pc_n   = {rdata, lat_lo};
        addr_n = {rdata, lat_lo};
      end
      S_R6: begin
        pc_n   = pc_inc;
        addr_n = pc_inc;
      end
      // indirect jump
      S_I2: begin
        lat_lo_n = rdata;
        pc_n     = pc_inc;
        addr_n   = pc_inc;
      end
      S_I3: begin
        lat_hi_n = rdata;
        pc_n     = pc_inc;
        addr_n   = {rdata, lat_lo};
      end
      S_I4: begin
        pc_n   = {pc[ADDR_W-1:DATA_W], rdata};
        addr_n = {lat_hi, lat_lo_inc};
      end
      S_I5: begin
        pc_n   = {rdata, pc[DATA_W-1:0]};
        addr_n = {rdata, pc[DATA_W-1:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= ADDR_W'(PC_RESET);
      bus_addr  <= ADDR_W'(PC_RESET);
      bus_we    <= 1'b0;
      bus_wdata <= '0;
      lat_lo    <= '0;
      lat_hi    <= '0;
    end else begin
      pc        <= pc_n;
      bus_addr  <= addr_n;
      bus_we    <= we_n;
      bus_wdata <= wd_n;
      lat_lo    <= lat_lo_n;
      lat_hi    <= lat_hi_n;
    end
  end

endmodule

// File: rtl/callseq_top.sv
module callseq_top
  import callseq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_RESET   = 8'hFD,
  parameter logic [15:0] PC_RESET   = 16'h0000,
  localparam int         ADDR_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              done
);

  step_e step;
  logic  launch;

  callseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .step(step), .launch(launch), .busy(busy), .done(done)
  );

  callseq_datapath #(
    .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE),
    .SP_RESET(SP_RESET), .PC_RESET(PC_RESET)
  ) u_dp (
    .clk(clk), .rst(rst), .step(step), .launch(launch), .rdata(rdata),
    .pc(pc), .sp(sp), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata)
  );

endmodule

// File: rtl/callseq_checker.sv
module callseq_checker #(
  parameter int         DATA_W     = 8,
  parameter logic [7:0] STACK_PAGE = 8'h01,
  localparam int        ADDR_W     = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] sp,
  input logic              busy,
  input logic              done
);

  assert_idle_read_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_addr == pc) && !bus_we);

  assert_push_hi_R4: assert property (@(posedge clk) disable iff (rst)
    bus_we && !$past(bus_we) |-> bus_wdata == pc[ADDR_W-1:DATA_W]);

  assert_push_lo_R4: assert property (@(posedge clk) disable iff (rst)
    bus_we && $past(bus_we) |->
      (bus_wdata == pc[DATA_W-1:0]) &&
      (bus_addr[DATA_W-1:0] == DATA_W'($past(bus_addr[DATA_W-1:0]) - 1'b1)));

  assert_sp_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> (sp == DATA_W'($past(sp) + 1'b1)) ||
                     (sp == DATA_W'($past(sp) - 1'b1)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  assert_we_page_R12: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_addr[ADDR_W-1:DATA_W] == DATA_W'(STACK_PAGE));

  assert_we_pair_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we) |=> bus_we);

endmodule

bind callseq_top callseq_checker #(
  .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pc(pc), .sp(sp), .busy(busy), .done(done)
);

// File: tb/callseq_top_test.sv
`timescale 1ns/1ps
module callseq_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [7:0]  rdata = 8'h00;
  logic [15:0] bus_addr, pc;
  logic        bus_we, busy, done;
  logic [7:0]  bus_wdata, sp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  mem [int];
  logic [15:0] pc_m;
  logic [7:0]  sp_m;

  always #2.5 clk = ~clk;

  callseq_top #(.PC_RESET(16'h8000), .SP_RESET(8'h01)) uut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .rdata(rdata), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pc(pc), .sp(sp), .busy(busy), .done(done)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge clk) rdata <= rd(bus_addr);
  always @(posedge clk) if (!rst && bus_we) mem[int'(bus_addr)] = bus_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Runs one instruction from the current idle negedge; model from requirements.
  task automatic exec(input logic [1:0] k, input bit poke, input string req);
    logic [15:0] ea[$];
    logic        ew[$];
    logic [7:0]  ed[$];
    logic [15:0] npc, p2;
    logic [7:0]  nsp, lo, hi, pl, ph;
    p2 = pc_m + 16'd2;
    case (k)
      2'b01: begin
        ea = '{pc_m + 16'd1, {8'h01, sp_m}, {8'h01, sp_m}, {8'h01, 8'(sp_m - 8'd1)}, p2};
        ew = '{0, 0, 1, 1, 0};
        ed = '{8'h00, 8'h00, p2[15:8], p2[7:0], 8'h00};
        npc = {rd(p2), rd(pc_m + 16'd1)};
        nsp = sp_m - 8'd2;
      end
      2'b10: begin
        lo = rd({8'h01, 8'(sp_m + 8'd1)});
        hi = rd({8'h01, 8'(sp_m + 8'd2)});
        ea = '{pc_m + 16'd1, {8'h01, sp_m}, {8'h01, 8'(sp_m + 8'd1)},
               {8'h01, 8'(sp_m + 8'd2)}, {hi, lo}};
        ew = '{0, 0, 0, 0, 0};
        ed = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        npc = {hi, lo} + 16'd1;
        nsp = sp_m + 8'd2;
      end
      default: begin
        pl = rd(pc_m + 16'd1);
        ph = rd(p2);
        ea = '{pc_m + 16'd1, p2, {ph, pl}, {ph, 8'(pl + 8'd1)}};
        ew = '{0, 0, 0, 0};
        ed = '{8'h00, 8'h00, 8'h00, 8'h00};
        npc = {rd({ph, 8'(pl + 8'd1)}), rd({ph, pl})};
        nsp = sp_m;
      end
    endcase
    chk(bus_addr == pc_m && !bus_we, "R2", "idle fetch addr", bus_addr, pc_m);
    op_start = 1'b1;
    op_kind  = k;
    @(negedge clk);
    op_start = 1'b0;
    op_kind  = 2'b00;
    for (int i = 0; i < ea.size(); i++) begin
      chk(bus_addr == ea[i], req, $sformatf("addr cycle %0d", i + 2), bus_addr, ea[i]);
      chk(bus_we == ew[i], "R12", $sformatf("we cycle %0d", i + 2), bus_we, ew[i]);
      if (ew[i]) chk(bus_wdata == ed[i], "R4", $sformatf("push data cycle %0d", i + 2),
                     bus_wdata, ed[i]);
      chk(busy && !done, "R11", "busy in sequence", {busy, done}, 2'b10);
      if (poke && i == 1) begin
        op_start = 1'b1;
        op_kind  = 2'b10;
      end else begin
        op_start = 1'b0;
        op_kind  = 2'b00;
      end
      @(negedge clk);
    end
    op_start = 1'b0;
    op_kind  = 2'b00;
    chk(!busy && done, "R11", "done pulse", {busy, done}, 2'b01);
    chk(pc == npc, req, "final pc", pc, npc);
    chk(sp == nsp, "R10", "final sp", sp, nsp);
    chk(bus_addr == npc, "R2", "next fetch addr", bus_addr, npc);
    pc_m = npc;
    sp_m = nsp;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mem[16'h8001] = 8'h34; mem[16'h8002] = 8'h12;
    mem[16'h1235] = 8'hFF; mem[16'h1236] = 8'h02;
    mem[16'h02FF] = 8'h78; mem[16'h0200] = 8'h56; mem[16'h0300] = 8'h99;
    mem[16'h5679] = 8'h00; mem[16'h567A] = 8'h40;
    mem[16'h8004] = 8'h10; mem[16'h8005] = 8'h03;
    mem[16'h0310] = 8'hCD; mem[16'h0311] = 8'hAB;
    pc_m = 16'h8000;
    sp_m = 8'h01;
    repeat (3) @(negedge clk);
    // R1: state during reset and just after
    chk(pc == 16'h8000 && sp == 8'h01, "R1", "reset pc/sp", {pc, sp}, {16'h8000, 8'h01});
    chk(bus_addr == 16'h8000 && !bus_we && !busy && !done, "R1", "reset bus",
        {bus_addr, bus_we, busy, done}, {16'h8000, 3'b000});
    rst = 1'b0;
    @(negedge clk);
    chk(pc == 16'h8000 && !busy && !done, "R1", "after reset", {pc, busy, done}, {16'h8000, 2'b00});
    // R2: start with empty kind is ignored
    op_start = 1'b1; op_kind = 2'b00;
    @(negedge clk);
    op_start = 1'b0;
    @(negedge clk);
    chk(!busy && pc == 16'h8000 && bus_addr == 16'h8000, "R2", "empty kind ignored",
        {busy, pc}, {1'b0, 16'h8000});
    // R3 R4 R5 R10: call 8000 -> 1234, pushes wrap sp 01 -> FF
    exec(2'b01, 0, "R3");
    chk(pc == 16'h1234, "R5", "call target", pc, 16'h1234);
    chk(mem[16'h0101] == 8'h80 && mem[16'h0100] == 8'h02, "R4", "stacked 8002",
        {mem[16'h0101], mem[16'h0100]}, 16'h8002);
    // R8 R9: pointer at page end wraps within its page
    exec(2'b11, 0, "R8");
    chk(pc == 16'h5678, "R9", "page-wrap target", pc, 16'h5678);
    // R2: call with a start poked mid-sequence, which must be ignored
    exec(2'b01, 1, "R3");
    chk(pc == 16'h4000 && sp == 8'hFD, "R2", "busy start ignored", {pc, sp}, {16'h4000, 8'hFD});
    // R6 R7: unwind both calls
    exec(2'b10, 0, "R6");
    chk(pc == 16'h567B, "R7", "inner resume", pc, 16'h567B);
    exec(2'b10, 0, "R6");
    chk(pc == 16'h8003 && sp == 8'h01, "R7", "outer resume, sp wrapped back",
        {pc, sp}, {16'h8003, 8'h01});
    // R8: in-page pointer
    exec(2'b11, 0, "R8");
    chk(pc == 16'hABCD, "R8", "indirect target", pc, 16'hABCD);
    repeat (2) @(negedge clk);
    chk(!busy && !done && bus_addr == 16'hABCD, "R11", "done only one cycle",
        {busy, done}, 2'b00);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule